// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an asynchronous serial input line into characters. It runs on the system clock and is paced by a tick that pulses once per sixteenth of a bit time. A falling edge on the synchronized line starts a candidate character. The block confirms the start bit half a bit later, then samples each following bit once per bit time. It collects 5 to 8 data bits, least significant bit first. It can also sample a parity bit and then a single stop bit.

Each character is presented for one clock cycle together with three flags: parity error, framing error and break. These flags are meant to be stored with the byte in a downstream receive buffer. Line-format inputs select the character length and the parity handling. A loopback select feeds the local transmitter output into the receiver in place of the external pin. A one-cycle start indication lets flow-control logic react as soon as a genuine start bit is confirmed.

Top module: `serial_rx_tagger`

## Requirements
- R1: The selected line passes through a two-flop synchronizer. A high-to-low transition on the synchronized line begins a candidate character. Eight ticks later the line is checked again. If it is still low, the start is accepted and `startSeen` pulses for one clock.
- R2: If the line is high at the mid-start check, the receiver returns to idle. It delivers no character and does not pulse `startSeen`.
- R3: After an accepted start, one bit is sampled every 16 ticks. Data bits arrive least significant bit first. The length is set by `charLen`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The unused upper bits of `rxData` read as zero.
- R4: When `parEn` is 1, one parity bit follows the data. `parMode` selects its expected value: 00 is even (data plus parity has an even number of ones), 01 is odd, 10 is always 1 and 11 is always 0. A mismatch sets `parErr` for that character. When `parEn` is 0, no parity bit is sampled and `parErr` is 0.
- R5: Exactly one stop bit is sampled after the data and parity bits. A low stop bit still delivers the character, with `frameErr` set. A high stop bit gives `frameErr` 0. The character is delivered at that first stop sample, whatever the length of the idle time after it.
- R6: If the line stays low from the start bit through the stop sample, the receiver delivers a single character. That character has `rxData` 0, `brkFlag` 1 and `frameErr` 1.
- R7: After a break, no new start is detected until the line has returned high. The line then needs a fresh falling edge.
- R8: When `loopEn` is 1, the receiver uses `loopTx` and ignores `rxPin`. When `loopEn` is 0, it uses `rxPin` and ignores `loopTx`.
- R9: `rxValid` is a single-cycle strobe, one per received character, and carries the data and the three flags. After reset, `rxValid`, `rxData`, `parErr`, `frameErr`, `brkFlag` and `startSeen` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| rxPin | input | 1 | External serial input, idle high |
| loopTx | input | 1 | Local transmitter output used in loopback |
| loopEn | input | 1 | 1 selects loopTx as the receive source |
| charLen | input | 2 | Character length code (5 + value bits) |
| parEn | input | 1 | Parity bit present |
| parMode | input | 2 | Parity kind: even, odd, always 1, always 0 |
| rxValid | output | 1 | One-cycle character strobe |
| rxData | output | 8 | Received character, upper unused bits zero |
| parErr | output | 1 | Parity mismatch on this character |
| frameErr | output | 1 | Stop bit sampled low |
| brkFlag | output | 1 | Character is a break |
| startSeen | output | 1 | One-cycle pulse on accepted start bit |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and an 8-bit data path. It drives `tick16` once every four clocks, so the mid-start check and each mid-bit sample land well inside the driven bit periods. It runs every character length, every parity kind and a low stop bit. It also covers a short glitch that must be rejected, a break of twenty bit times followed by a normal character, and the loopback path while the external pin is held low.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } rxState_t;

  typedef struct packed {
    logic clearData;
    logic sampleData;
    logic samplePar;
    logic finish;
  } rxStrobe_t;

endpackage

// File: rtl/rxtag_ctrl.sv
module rxtag_ctrl
  import rxtag_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int IDX_W         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             rxS,
  input  logic             fallEdge,
  input  logic             breakNow,
  input  logic [1:0]       charLen,
  input  logic             parEn,
  output rxStrobe_t        strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             startSeen
);

  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(TICKS_PER_BIT - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic             midStart;
  logic             bitEnd;
  logic             lastBit;

  assign midStart = tick && (tickCnt == HALF_M1);
  assign bitEnd   = tick && (tickCnt == FULL_M1);
  assign lastBit  = (bitIdx == IDX_W'({1'b0, charLen} + 3'd4));

  always_comb begin
    strobe.clearData  = (state == S_START) && midStart && !rxS;
    strobe.sampleData = (state == S_DATA) && bitEnd;
    strobe.samplePar  = (state == S_PAR) && bitEnd;
    strobe.finish     = (state == S_STOP) && bitEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      startSeen <= 1'b0;
    end else begin
      startSeen <= 1'b0;
      case (state)
        S_IDLE: begin
          tickCnt <= '0;
          if (fallEdge) state <= S_START;
        end
        S_START: begin
          if (midStart) begin
            tickCnt <= '0;
            if (!rxS) begin
              state     <= S_DATA;
              bitIdx    <= '0;
              startSeen <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (bitEnd) begin
            tickCnt <= '0;
            if (lastBit) state <= parEn ? S_PAR : S_STOP;
            else         bitIdx <= bitIdx + 1'b1;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= S_STOP;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= breakNow ? S_WAITHI : S_IDLE;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_WAITHI: begin
          tickCnt <= '0;
          if (rxS) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |-> $past(!rxS)); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearData, strobe.sampleData, strobe.samplePar, strobe.finish})); // R9

  AST_WAIT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITHI) |=> !startSeen); // R7

endmodule

// File: rtl/rxtag_dpath.sv
module rxtag_dpath
  import rxtag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  logic              loopTx,
  input  logic              loopEn,
  input  rxStrobe_t         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              parEn,
  input  logic [1:0]        parMode,
  output logic              rxS,
  output logic              fallEdge,
  output logic              breakNow,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              parErr,
  output logic              frameErr,
  output logic              brkFlag
);

  logic              lineSel;
  logic              syncA;
  logic              syncB;
  logic              prevS;
  logic [DATA_W-1:0] dataReg;
  logic              parBit;
  logic              expPar;

  assign lineSel  = loopEn ? loopTx : rxPin;
  assign rxS      = syncB;
  assign fallEdge = prevS && !syncB;
  assign breakNow = (dataReg == '0) && !parBit && !syncB;

  always_comb begin
    case (parMode)
      2'd0:    expPar = ^dataReg;
      2'd1:    expPar = ~^dataReg;
      2'd2:    expPar = 1'b1;
      default: expPar = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      prevS <= 1'b1;
    end else begin
      syncA <= lineSel;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      parBit  <= 1'b0;
    end else if (strobe.clearData) begin
      dataReg <= '0;
      parBit  <= 1'b0;
    end else if (strobe.sampleData) begin
      dataReg[bitIdx] <= syncB;
    end else if (strobe.samplePar) begin
      parBit <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid  <= 1'b0;
      rxData   <= '0;
      parErr   <= 1'b0;
      frameErr <= 1'b0;
      brkFlag  <= 1'b0;
    end else begin
      rxValid <= strobe.finish;
      if (strobe.finish) begin
        rxData   <= dataReg;
        parErr   <= parEn && (parBit != expPar);
        frameErr <= !syncB;
        brkFlag  <= breakNow;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R9

  AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && brkFlag) |-> (rxData == '0) && frameErr); // R6

endmodule

// File: rtl/serial_rx_tagger.sv
module serial_rx_tagger
  import rxtag_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxPin,
  input  logic              loopTx,
  input  logic              loopEn,
  input  logic [1:0]        charLen,
  input  logic              parEn,
  input  logic [1:0]        parMode,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              parErr,
  output logic              frameErr,
  output logic              brkFlag,
  output logic              startSeen
);

  localparam int IDX_W = $clog2(DATA_W);

  rxStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;
  logic             rxS;
  logic             fallEdge;
  logic             breakNow;

  rxtag_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .IDX_W        (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick16),
    .rxS      (rxS),
    .fallEdge (fallEdge),
    .breakNow (breakNow),
    .charLen  (charLen),
    .parEn    (parEn),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .startSeen(startSeen)
  );

  rxtag_dpath #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .rxPin   (rxPin),
    .loopTx  (loopTx),
    .loopEn  (loopEn),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .parEn   (parEn),
    .parMode (parMode),
    .rxS     (rxS),
    .fallEdge(fallEdge),
    .breakNow(breakNow),
    .rxValid (rxValid),
    .rxData  (rxData),
    .parErr  (parErr),
    .frameErr(frameErr),
    .brkFlag (brkFlag)
  );

  AST_NOPAR_NOERR: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parEn) |-> !parErr); // R4

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && charLen == 2'd0) |-> (rxData[DATA_W-1:5] == '0)); // R3

endmodule

// File: tb/serial_rx_tagger_bench.sv
module serial_rx_tagger_bench;

  localparam int CLK_PER_TICK = 4;
  localparam int CLK_PER_BIT  = CLK_PER_TICK * 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxPin = 1'b1;
  logic       loopTx = 1'b1;
  logic       loopEn = 1'b0;
  logic [1:0] charLen = 2'd3;
  logic       parEn = 1'b0;
  logic [1:0] parMode = 2'd0;
  logic       rxValid;
  logic [7:0] rxData;
  logic       parErr;
  logic       frameErr;
  logic       brkFlag;
  logic       startSeen;

  int errors = 0;
  int checks = 0;
  int gotCnt = 0;
  int startCnt = 0;
  logic [7:0] lastData = '0;
  logic       lastPar = 1'b0;
  logic       lastFrame = 1'b0;
  logic       lastBrk = 1'b0;
  int tickDiv = 0;

  always #5 clk = ~clk;

  serial_rx_tagger u_serial_rx_tagger (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxPin(rxPin), .loopTx(loopTx),
    .loopEn(loopEn), .charLen(charLen), .parEn(parEn), .parMode(parMode),
    .rxValid(rxValid), .rxData(rxData), .parErr(parErr), .frameErr(frameErr),
    .brkFlag(brkFlag), .startSeen(startSeen)
  );

  always @(posedge clk) begin
    tickDiv <= (tickDiv == CLK_PER_TICK - 1) ? 0 : tickDiv + 1;
    tick16  <= (tickDiv == CLK_PER_TICK - 1);
  end

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      gotCnt    <= gotCnt + 1;
      lastData  <= rxData;
      lastPar   <= parErr;
      lastFrame <= frameErr;
      lastBrk   <= brkFlag;
    end
    if (rstN && startSeen) startCnt <= startCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic v, input bit useLoop);
    if (useLoop) loopTx = v; else rxPin = v;
    repeat (CLK_PER_BIT) @(negedge clk);
  endtask

  function automatic logic parVal(input logic [7:0] d, input int len, input logic [1:0] m);
    int ones = 0;
    for (int i = 0; i < len; i++) ones += d[i];
    case (m)
      2'd0: return logic'(ones % 2);
      2'd1: return logic'((ones + 1) % 2);
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sendChar(input logic [7:0] d, input int len, input bit withPar,
                          input logic pBit, input logic stopBit, input bit useLoop);
    driveBit(1'b0, useLoop);
    for (int i = 0; i < len; i++) driveBit(d[i], useLoop);
    if (withPar) driveBit(pBit, useLoop);
    driveBit(stopBit, useLoop);
    driveBit(1'b1, useLoop);
    driveBit(1'b1, useLoop);
  endtask

  task automatic runChar(input string req, input logic [7:0] d, input int len,
                         input bit withPar, input logic [1:0] mode, input bit flipPar,
                         input logic stopBit, input bit useLoop,
                         input logic [7:0] expData, input logic expPErr, input logic expFErr);
    int c0 = gotCnt;
    int s0 = startCnt;
    logic pb;
    charLen = 2'(len - 5);
    parEn   = withPar;
    parMode = mode;
    pb = parVal(d, len, mode) ^ flipPar;
    sendChar(d, len, withPar, pb, stopBit, useLoop);
    chk(gotCnt == c0 + 1, {req, " count"}, gotCnt - c0, 1);
    chk(startCnt == s0 + 1, {req, " start"}, startCnt - s0, 1);
    chk(lastData == expData, {req, " data"}, lastData, expData);
    chk(lastPar == expPErr, {req, " parErr"}, lastPar, expPErr);
    chk(lastFrame == expFErr, {req, " frameErr"}, lastFrame, expFErr);
    chk(lastBrk == 1'b0, {req, " brkFlag"}, lastBrk, 0);
  endtask

  task automatic testReset();
    chk(!rxValid && rxData == 0 && !parErr && !frameErr && !brkFlag && !startSeen,
        "R9 reset", {rxValid, rxData, parErr, frameErr, brkFlag, startSeen}, 0);
  endtask

  task automatic testLengths();
    runChar("R1 R3 8bit", 8'hA5, 8, 0, 2'd0, 0, 1'b1, 0, 8'hA5, 0, 0);
    runChar("R3 5bit", 8'hFF, 5, 0, 2'd0, 0, 1'b1, 0, 8'h1F, 0, 0);
    runChar("R3 6bit", 8'h2D, 6, 0, 2'd0, 0, 1'b1, 0, 8'h2D, 0, 0);
    runChar("R3 7bit", 8'hC1, 7, 0, 2'd0, 0, 1'b1, 0, 8'h41, 0, 0);
  endtask

  task automatic testParity();
    runChar("R4 even ok", 8'h37, 8, 1, 2'd0, 0, 1'b1, 0, 8'h37, 0, 0);
    runChar("R4 even bad", 8'h37, 8, 1, 2'd0, 1, 1'b1, 0, 8'h37, 1, 0);
    runChar("R4 odd ok", 8'h12, 7, 1, 2'd1, 0, 1'b1, 0, 8'h12, 0, 0);
    runChar("R4 odd bad", 8'h12, 7, 1, 2'd1, 1, 1'b1, 0, 8'h12, 1, 0);
    runChar("R4 mark bad", 8'h0F, 6, 1, 2'd2, 1, 1'b1, 0, 8'h0F, 1, 0);
    runChar("R4 space ok", 8'h15, 5, 1, 2'd3, 0, 1'b1, 0, 8'h15, 0, 0);
  endtask

  task automatic testStop();
    runChar("R5 stop low", 8'h81, 8, 0, 2'd0, 0, 1'b0, 0, 8'h81, 0, 1);
    runChar("R5 stop low parity", 8'h80, 8, 1, 2'd2, 0, 1'b0, 0, 8'h80, 0, 1);
  endtask

  task automatic testFalseStart();
    int c0 = gotCnt;
    int s0 = startCnt;
    rxPin = 1'b0;
    repeat (3 * CLK_PER_TICK) @(negedge clk);
    rxPin = 1'b1;
    repeat (3 * CLK_PER_BIT) @(negedge clk);
    chk(gotCnt == c0, "R2 no char", gotCnt - c0, 0);
    chk(startCnt == s0, "R2 no start", startCnt - s0, 0);
  endtask

  task automatic testBreak();
    int c0 = gotCnt;
    int s0 = startCnt;
    charLen = 2'd3;
    parEn   = 1'b0;
    rxPin   = 1'b0;
    repeat (20 * CLK_PER_BIT) @(negedge clk);
    chk(gotCnt == c0 + 1, "R6 R7 one char during break", gotCnt - c0, 1);
    chk(startCnt == s0 + 1, "R7 one start during break", startCnt - s0, 1);
    chk(lastData == 8'h00, "R6 break data", lastData, 0);
    chk(lastBrk == 1'b1, "R6 break flag", lastBrk, 1);
    chk(lastFrame == 1'b1, "R6 break frameErr", lastFrame, 1);
    rxPin = 1'b1;
    repeat (2 * CLK_PER_BIT) @(negedge clk);
    runChar("R7 after break", 8'h3C, 8, 0, 2'd0, 0, 1'b1, 0, 8'h3C, 0, 0);
  endtask

  task automatic testLoop();
    loopEn = 1'b1;
    rxPin  = 1'b0;
    repeat (CLK_PER_BIT) @(negedge clk);
    runChar("R8 loopback", 8'h5A, 8, 1, 2'd1, 0, 1'b1, 1, 8'h5A, 0, 0);
    rxPin = 1'b1;
    repeat (CLK_PER_BIT) @(negedge clk);
    loopEn = 1'b0;
    loopTx = 1'b0;
    repeat (CLK_PER_BIT) @(negedge clk);
    runChar("R8 pin path", 8'hE7, 8, 0, 2'd0, 0, 1'b1, 0, 8'hE7, 0, 0);
    loopTx = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2 * CLK_PER_BIT) @(negedge clk);
    testLengths();
    testParity();
    testStop();
    testFalseStart();
    testBreak();
    testLoop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule